// File: doc/BRIEF.md
# Twelve-Bit Accumulator Execution Unit

This block is the execution core of a small 12-bit accumulator machine. Each micro-operation arrives already decoded, one per command. The block holds these registers:

- the accumulator and a second, backup accumulator;
- a carry flag;
- the two most recent compare operands;
- a 4-bit page register;
- an 8-bit RAM index register;
- a 12-bit jump-target register;
- a program counter.

Each accepted command updates these registers at one clock edge and raises `done_o` for one cycle.

Data memory and table memory sit outside the block. Their addresses and write data come straight from the command and the current registers. Read data is used in the same cycle, and RAM writes take effect at the clock edge.

The parameter `MSIZE` sets the program space: code 0 gives 4K words, 1 gives 8K, 2 gives 16K and 3 gives 32K. The program counter and the table-memory address are 12+`MSIZE` bits wide. The bits above the low twelve form the current page, which a long jump selects.

Top module: `acc12_exec`

## Requirements
- R1: While reset is asserted, and after it is released with no command, every register output, `done_o`, `ram_we_o` and the skip flag read zero.
- R2: Add-immediate (opcode 2) adds `cmd_imm`. Add-memory (opcode 3) adds the RAM word at the index register. Both store the 13-bit sum masked to 12 bits in A and set the carry to bit 12 of the sum.
- R3: Each operand-fetching operation saves the old A as the "old" compare operand and its incoming value as the "new" compare operand. The operand-fetching operations are opcodes 1, 2, 3, 4, 5 and 9. Jump-if-equal (opcode 11) loads PC with {current page, J} when the two saved operands are equal, and otherwise PC advances by one.
- R4: Compare-direct (opcode 5) reads RAM at {P, `cmd_ofs`}, loads that address into the index register, and leaves A unchanged. It sets the carry to bit 12 of (operand XOR 0xFFF) + 1 + A.
- R5: Jump-if-no-carry (opcode 10) loads PC with {current page, J} when the carry is clear, and otherwise PC advances by one.
- R6: Store-direct (opcode 6) writes A to RAM at {P, `cmd_ofs`} and loads that address into the index register. Store-indirect (opcode 7) writes A to RAM at the index register. Store-backup (opcode 15) writes B at the index register. Copy-to-backup (opcode 0) sets B to A. No other opcode asserts `ram_we_o`.
- R7: Load-index (opcode 8) loads the index register with the low 8 bits of the RAM word at {P, `cmd_ofs`}.
- R8: Translate (opcode 9) replaces A with the zero-extended table byte addressed by A, and leaves the carry unchanged. The next command is then skipped: it changes no register other than PC, which advances by one, writes no RAM, and clears the skip flag.
- R9: Long jump (opcode 12) loads PC with {P[MSIZE-1:0], J}, and later local jumps keep those upper PC bits. Load-page (opcode 13) sets P to `cmd_imm[3:0]`. Load-jump (opcode 14) sets J to `cmd_imm`.
- R10: The table-memory address is 12+`MSIZE` bits wide and always equals A zero-extended.
- R11: High-nibble load (opcode 1) sets A to `cmd_imm[3:0]` shifted left by 8. Load-memory (opcode 4) sets A to the RAM word at the index register. Both clear the carry.
- R12: Every command with `cmd_valid` high raises `done_o` exactly in the following cycle. Every executed non-jump command advances PC by one, modulo the PC width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | A decoded command is present this cycle |
| cmd_op | input | 4 | Micro-operation code |
| cmd_imm | input | 12 | Immediate value |
| cmd_ofs | input | 4 | Offset within the current RAM page |
| done_o | output | 1 | One-cycle pulse after each command |
| ram_addr_o | output | 8 | RAM address |
| ram_we_o | output | 1 | RAM write enable |
| ram_wdata_o | output | 12 | RAM write data |
| ram_rdata_i | input | 12 | RAM read data for `ram_addr_o`, same cycle |
| rom_addr_o | output | 14 | Table-memory address |
| rom_rdata_i | input | 8 | Table byte for `rom_addr_o`, same cycle |
| acc_o | output | 12 | Accumulator A |
| carry_o | output | 1 | Carry flag |
| pc_o | output | 14 | Program counter |
| page_o | output | 4 | Page register P |
| idx_o | output | 8 | RAM index register |
| skip_o | output | 1 | The next command will be skipped |

## Verification
Every register result, including PC and `done_o`, is due at the first rising edge after the command is presented. A RAM write lands in the external memory at that same edge. The bench drives each command at a falling edge and removes it at the next falling edge. It then compares A, carry, PC, P, I, the skip flag, `done_o` and any written RAM word against its own model. It does this half a cycle after the edge, so every result is read one register stage after its cause. A skip set by translate is checked on the following command, which must leave every result but PC unchanged.

// File: rtl/acc12_pkg.sv
package acc12_pkg;
  typedef enum logic [3:0] {
    OP_MOVB = 4'd0,
    OP_LDHI = 4'd1,
    OP_ADDI = 4'd2,
    OP_ADDM = 4'd3,
    OP_LDM  = 4'd4,
    OP_CMPD = 4'd5,
    OP_STD  = 4'd6,
    OP_STI  = 4'd7,
    OP_LDIX = 4'd8,
    OP_XLT  = 4'd9,
    OP_JNC  = 4'd10,
    OP_JEQ  = 4'd11,
    OP_LJMP = 4'd12,
    OP_LDP  = 4'd13,
    OP_LDJ  = 4'd14,
    OP_STB  = 4'd15
  } op_e;
endpackage

// File: rtl/acc12_alu.sv
module acc12_alu #(
  parameter int DW = 12
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] opnd_i,
  input  logic          sub_i,
  output logic [DW:0]   sum_o
);
  // One adder serves both add and compare: compare adds the
  // inverted operand plus one, so only the carry is of interest.
  always_comb begin
    if (sub_i) sum_o = {1'b0, ~opnd_i} + {1'b0, a_i} + {{DW{1'b0}}, 1'b1};
    else       sum_o = {1'b0, a_i} + {1'b0, opnd_i};
  end
endmodule

// File: rtl/acc12_agen.sv
module acc12_agen
  import acc12_pkg::*;
#(
  parameter int PGW = 4,
  parameter int OFW = 4
) (
  input  op_e                 op_i,
  input  logic [PGW-1:0]      page_i,
  input  logic [OFW-1:0]      ofs_i,
  input  logic [PGW+OFW-1:0]  idx_i,
  output logic [PGW+OFW-1:0]  dir_addr_o,
  output logic [PGW+OFW-1:0]  mem_addr_o
);
  logic direct;

  assign dir_addr_o = {page_i, ofs_i};

  always_comb begin
    direct = (op_i == OP_CMPD) || (op_i == OP_STD) || (op_i == OP_LDIX);
    mem_addr_o = direct ? dir_addr_o : idx_i;
  end
endmodule

// File: rtl/acc12_pcu.sv
module acc12_pcu
  import acc12_pkg::*;
#(
  parameter int DW    = 12,
  parameter int PGW   = 4,
  parameter int MSIZE = 2
) (
  input  logic [DW+MSIZE-1:0] pc_i,
  input  logic [DW-1:0]       jmp_i,
  input  logic [PGW-1:0]      page_i,
  input  op_e                 op_i,
  input  logic                exec_i,
  input  logic                carry_i,
  input  logic                eq_i,
  output logic [DW+MSIZE-1:0] pc_next_o
);
  localparam int AW = DW + MSIZE;

  logic [AW-1:0] pc_inc, local_tgt, far_tgt;

  assign pc_inc = pc_i + AW'(1);

  generate
    if (MSIZE > 0) begin : g_paged
      assign local_tgt = {pc_i[AW-1:DW], jmp_i};
      assign far_tgt   = {page_i[MSIZE-1:0], jmp_i};
    end else begin : g_flat
      assign local_tgt = jmp_i;
      assign far_tgt   = jmp_i;
    end
  endgenerate

  always_comb begin
    pc_next_o = pc_inc;
    if (exec_i) begin
      case (op_i)
        OP_JNC:  if (!carry_i) pc_next_o = local_tgt;
        OP_JEQ:  if (eq_i)     pc_next_o = local_tgt;
        OP_LJMP: pc_next_o = far_tgt;
        default: pc_next_o = pc_inc;
      endcase
    end
  end
endmodule

// File: rtl/acc12_exec.sv
module acc12_exec
  import acc12_pkg::*;
#(
  parameter int DW    = 12,
  parameter int PGW   = 4,
  parameter int OFW   = 4,
  parameter int BYTEW = 8,
  parameter int MSIZE = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  input  logic [3:0]           cmd_op,
  input  logic [DW-1:0]        cmd_imm,
  input  logic [OFW-1:0]       cmd_ofs,
  output logic                 done_o,
  output logic [PGW+OFW-1:0]   ram_addr_o,
  output logic                 ram_we_o,
  output logic [DW-1:0]        ram_wdata_o,
  input  logic [DW-1:0]        ram_rdata_i,
  output logic [DW+MSIZE-1:0]  rom_addr_o,
  input  logic [BYTEW-1:0]     rom_rdata_i,
  output logic [DW-1:0]        acc_o,
  output logic                 carry_o,
  output logic [DW+MSIZE-1:0]  pc_o,
  output logic [PGW-1:0]       page_o,
  output logic [PGW+OFW-1:0]   idx_o,
  output logic                 skip_o
);
  localparam int RAW    = PGW + OFW;
  localparam int ROM_AW = DW + MSIZE;
  localparam int NIB    = 4;

  // reset synchronizer: assert asynchronously, release on clock
  logic rst_s1, rst_n_int;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1    <= 1'b0;
      rst_n_int <= 1'b0;
    end else begin
      rst_s1    <= 1'b1;
      rst_n_int <= rst_s1;
    end
  end

  // architectural state
  logic [DW-1:0]     acc_q, acc_d, bak_q, bak_d, old_q, old_d, new_q, new_d, jmp_q, jmp_d;
  logic              carry_q, carry_d, skip_q, skip_d, done_q;
  logic [PGW-1:0]    page_q, page_d;
  logic [RAW-1:0]    idx_q, idx_d;
  logic [ROM_AW-1:0] pc_q, pc_d;

  op_e            op;
  logic           exec;
  logic [RAW-1:0] dir_addr;
  logic [DW:0]    sum;
  logic [DW-1:0]  alu_opnd, xlt_val, hi_val;

  assign op       = op_e'(cmd_op);
  assign exec     = cmd_valid && !skip_q;
  assign alu_opnd = (op == OP_ADDI) ? cmd_imm : ram_rdata_i;
  assign xlt_val  = DW'(rom_rdata_i);
  assign hi_val   = {cmd_imm[NIB-1:0], {(DW-NIB){1'b0}}};

  acc12_alu #(.DW(DW)) u_alu (
    .a_i    (acc_q),
    .opnd_i (alu_opnd),
    .sub_i  (op == OP_CMPD),
    .sum_o  (sum)
  );

  acc12_agen #(.PGW(PGW), .OFW(OFW)) u_agen (
    .op_i       (op),
    .page_i     (page_q),
    .ofs_i      (cmd_ofs),
    .idx_i      (idx_q),
    .dir_addr_o (dir_addr),
    .mem_addr_o (ram_addr_o)
  );

  acc12_pcu #(.DW(DW), .PGW(PGW), .MSIZE(MSIZE)) u_pcu (
    .pc_i      (pc_q),
    .jmp_i     (jmp_q),
    .page_i    (page_q),
    .op_i      (op),
    .exec_i    (exec),
    .carry_i   (carry_q),
    .eq_i      (new_q == old_q),
    .pc_next_o (pc_d)
  );

  // memory-side outputs
  assign ram_we_o    = exec && ((op == OP_STD) || (op == OP_STI) || (op == OP_STB));
  assign ram_wdata_o = (op == OP_STB) ? bak_q : acc_q;
  assign rom_addr_o  = ROM_AW'(acc_q);

  // next-state logic
  always_comb begin
    acc_d   = acc_q;
    bak_d   = bak_q;
    old_d   = old_q;
    new_d   = new_q;
    jmp_d   = jmp_q;
    carry_d = carry_q;
    page_d  = page_q;
    idx_d   = idx_q;
    skip_d  = 1'b0;
    if (exec) begin
      case (op)
        OP_MOVB: bak_d = acc_q;
        OP_LDHI: begin old_d = acc_q; new_d = hi_val; acc_d = hi_val; carry_d = 1'b0; end
        OP_ADDI, OP_ADDM: begin
          old_d = acc_q; new_d = alu_opnd; acc_d = sum[DW-1:0]; carry_d = sum[DW];
        end
        OP_LDM:  begin old_d = acc_q; new_d = ram_rdata_i; acc_d = ram_rdata_i; carry_d = 1'b0; end
        OP_CMPD: begin old_d = acc_q; new_d = ram_rdata_i; carry_d = sum[DW]; idx_d = dir_addr; end
        OP_STD:  idx_d = dir_addr;
        OP_LDIX: idx_d = ram_rdata_i[RAW-1:0];
        OP_XLT:  begin old_d = acc_q; new_d = xlt_val; acc_d = xlt_val; skip_d = 1'b1; end
        OP_LDP:  page_d = cmd_imm[PGW-1:0];
        OP_LDJ:  jmp_d = cmd_imm;
        default: ;
      endcase
    end
  end

  // registers, clock-enabled by cmd_valid
  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      acc_q   <= '0;
      bak_q   <= '0;
      old_q   <= '0;
      new_q   <= '0;
      jmp_q   <= '0;
      carry_q <= 1'b0;
      skip_q  <= 1'b0;
      done_q  <= 1'b0;
      page_q  <= '0;
      idx_q   <= '0;
      pc_q    <= '0;
    end else begin
      done_q <= cmd_valid;
      if (cmd_valid) begin
        acc_q   <= acc_d;
        bak_q   <= bak_d;
        old_q   <= old_d;
        new_q   <= new_d;
        jmp_q   <= jmp_d;
        carry_q <= carry_d;
        skip_q  <= skip_d;
        page_q  <= page_d;
        idx_q   <= idx_d;
        pc_q    <= pc_d;
      end
    end
  end

  assign done_o  = done_q;
  assign acc_o   = acc_q;
  assign carry_o = carry_q;
  assign pc_o    = pc_q;
  assign page_o  = page_q;
  assign idx_o   = idx_q;
  assign skip_o  = skip_q;

  AST_ADD_RESULT: assert property (@(posedge clk) disable iff (!rst_n_int)
    (exec && op == OP_ADDI) |=> ({carry_q, acc_q} == ({1'b0, $past(acc_q)} + {1'b0, $past(cmd_imm)}))); // R2
  AST_CMP_KEEPS_ACC: assert property (@(posedge clk) disable iff (!rst_n_int)
    (exec && op == OP_CMPD) |=> $stable(acc_q)); // R4
  AST_JNC_TAKEN: assert property (@(posedge clk) disable iff (!rst_n_int)
    (exec && op == OP_JNC && !carry_q) |=> (pc_q[DW-1:0] == $past(jmp_q))); // R5
  AST_JEQ_TAKEN: assert property (@(posedge clk) disable iff (!rst_n_int)
    (exec && op == OP_JEQ && new_q == old_q) |=> (pc_q[DW-1:0] == $past(jmp_q))); // R3
  AST_SKIP_FREEZES: assert property (@(posedge clk) disable iff (!rst_n_int)
    (cmd_valid && skip_q) |=> ($stable(acc_q) && $stable(carry_q) && $stable(idx_q) && !skip_q)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n_int)
    cmd_valid |=> done_o); // R12
endmodule

// File: tb/acc12_exec_tb_top.sv
module acc12_exec_tb_top;
  import acc12_pkg::*;

  localparam int DW = 12, PGW = 4, OFW = 4, BYTEW = 8, MS = 2;
  localparam int RAW = PGW + OFW, AW = DW + MS;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic              rst_n, cmd_valid, done_o, ram_we, carry_o, skip_o;
  logic [3:0]        cmd_op;
  logic [DW-1:0]     cmd_imm, ram_wdata, ram_rdata, acc_o;
  logic [OFW-1:0]    cmd_ofs;
  logic [RAW-1:0]    ram_addr, idx_o;
  logic [AW-1:0]     rom_addr, pc_o;
  logic [BYTEW-1:0]  rom_rdata;
  logic [PGW-1:0]    page_o;

  acc12_exec #(.DW(DW), .PGW(PGW), .OFW(OFW), .BYTEW(BYTEW), .MSIZE(MS)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_imm(cmd_imm), .cmd_ofs(cmd_ofs), .done_o(done_o),
    .ram_addr_o(ram_addr), .ram_we_o(ram_we), .ram_wdata_o(ram_wdata),
    .ram_rdata_i(ram_rdata), .rom_addr_o(rom_addr), .rom_rdata_i(rom_rdata),
    .acc_o(acc_o), .carry_o(carry_o), .pc_o(pc_o), .page_o(page_o),
    .idx_o(idx_o), .skip_o(skip_o)
  );

  // environment memories
  logic [DW-1:0] mem [1<<RAW];
  always @(posedge clk) if (ram_we) mem[ram_addr] <= ram_wdata;
  assign ram_rdata = mem[ram_addr];

  function automatic logic [BYTEW-1:0] rom_fn(input logic [AW-1:0] a);
    logic [31:0] t;
    t = 32'(a) * 32'd13 + (32'(a) >> 6) + 32'd5;
    return t[BYTEW-1:0];
  endfunction
  assign rom_rdata = rom_fn(rom_addr);

  // reference model
  logic [DW-1:0]  m_a, m_b, m_old, m_new, m_j;
  logic [DW-1:0]  m_mem [1<<RAW];
  logic           m_c, m_skip;
  logic [PGW-1:0] m_p;
  logic [RAW-1:0] m_i;
  logic [AW-1:0]  m_pc;

  int checks = 0, errors = 0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic string req_of(input op_e op, input logic skipping);
    if (skipping) return "R8";
    case (op)
      OP_MOVB, OP_STD, OP_STI, OP_STB: return "R6";
      OP_LDHI, OP_LDM:                 return "R11";
      OP_ADDI, OP_ADDM:                return "R2";
      OP_CMPD:                         return "R4";
      OP_LDIX:                         return "R7";
      OP_XLT:                          return "R8";
      OP_JNC:                          return "R5";
      OP_JEQ:                          return "R3";
      default:                         return "R9";
    endcase
  endfunction

  task automatic run(input op_e op, input logic [DW-1:0] imm, input logic [OFW-1:0] ofs);
    string          tag;
    logic [RAW-1:0] dir, wa;
    logic [DW-1:0]  rd_dir, rd_i, wv;
    logic [DW:0]    s;
    logic           do_w;
    logic [AW-1:0]  pc_n;
    tag    = req_of(op, m_skip);
    dir    = {m_p, ofs};
    rd_dir = m_mem[dir];
    rd_i   = m_mem[m_i];
    do_w   = 1'b0;
    wa     = '0;
    wv     = '0;
    pc_n   = m_pc + AW'(1);
    if (m_skip) begin
      m_skip = 1'b0;
    end else begin
      case (op)
        OP_MOVB: m_b = m_a;
        OP_LDHI: begin m_old = m_a; m_new = {imm[3:0], 8'h00}; m_a = m_new; m_c = 1'b0; end
        OP_ADDI: begin s = {1'b0, m_a} + {1'b0, imm}; m_old = m_a; m_new = imm; m_a = s[DW-1:0]; m_c = s[DW]; end
        OP_ADDM: begin s = {1'b0, m_a} + {1'b0, rd_i}; m_old = m_a; m_new = rd_i; m_a = s[DW-1:0]; m_c = s[DW]; end
        OP_LDM:  begin m_old = m_a; m_new = rd_i; m_a = rd_i; m_c = 1'b0; end
        OP_CMPD: begin
          s = {1'b0, rd_dir ^ 12'hFFF} + 13'd1 + {1'b0, m_a};
          m_old = m_a; m_new = rd_dir; m_c = s[DW]; m_i = dir;
        end
        OP_STD:  begin m_i = dir; do_w = 1'b1; wa = dir; wv = m_a; end
        OP_STI:  begin do_w = 1'b1; wa = m_i; wv = m_a; end
        OP_LDIX: m_i = rd_dir[7:0];
        OP_XLT:  begin m_old = m_a; m_new = DW'(rom_fn(AW'(m_a))); m_a = m_new; m_skip = 1'b1; end
        OP_JNC:  if (!m_c) pc_n = {m_pc[AW-1:DW], m_j};
        OP_JEQ:  if (m_new == m_old) pc_n = {m_pc[AW-1:DW], m_j};
        OP_LJMP: pc_n = {m_p[MS-1:0], m_j};
        OP_LDP:  m_p = imm[3:0];
        OP_LDJ:  m_j = imm;
        OP_STB:  begin do_w = 1'b1; wa = m_i; wv = m_b; end
        default: ;
      endcase
    end
    m_pc = pc_n;
    if (do_w) m_mem[wa] = wv;

    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_imm = imm; cmd_ofs = ofs;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R12", "done", int'(done_o), 1);
    chk(tag, "acc", int'(acc_o), int'(m_a));
    chk(tag, "carry", int'(carry_o), int'(m_c));
    chk(tag, "pc", int'(pc_o), int'(m_pc));
    chk(tag, "page", int'(page_o), int'(m_p));
    chk(tag, "idx", int'(idx_o), int'(m_i));
    chk(tag, "skip", int'(skip_o), int'(m_skip));
    if (do_w) chk(tag, "ram word", int'(mem[wa]), int'(wv));
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    for (int k = 0; k < (1 << RAW); k++) begin mem[k] = '0; m_mem[k] = '0; end
    m_a = '0; m_b = '0; m_old = '0; m_new = '0; m_j = '0; m_c = 1'b0;
    m_skip = 1'b0; m_p = '0; m_i = '0; m_pc = '0;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = '0; cmd_imm = '0; cmd_ofs = '0;
    repeat (3) @(negedge clk);
    // R1: reset state, asserted then released
    chk("R1", "acc", int'(acc_o), 0);
    chk("R1", "pc", int'(pc_o), 0);
    chk("R1", "done", int'(done_o), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "carry/skip/we", int'({carry_o, skip_o, ram_we}), 0);
    chk("R1", "page/idx", int'({page_o, idx_o}), 0);
    chk("R10", "rom addr width", $bits(rom_addr), DW + MS);

    // directed: two-step immediate load, store, carry out, jumps
    run(OP_LDHI, 12'h00F, 4'h0);          // R11 A = F00
    run(OP_ADDI, 12'h001, 4'h0);          // R2 A = F01
    run(OP_LDP,  12'h000, 4'h0);
    run(OP_STD,  12'h000, 4'h0);          // R6 ram[00] = F01
    run(OP_ADDI, 12'h0FF, 4'h0);          // R2 A = 000, carry 1
    run(OP_LDJ,  12'h008, 4'h0);
    run(OP_JNC,  12'h000, 4'h0);          // R5 not taken
    run(OP_ADDI, 12'h001, 4'h0);          // carry 0
    run(OP_JNC,  12'h000, 4'h0);          // R5 taken
    run(OP_CMPD, 12'h000, 4'h0);          // R4 A < operand: carry 0
    run(OP_LDM,  12'h000, 4'h0);          // R11 A = F01
    run(OP_CMPD, 12'h000, 4'h0);          // R4 equal: carry 1
    run(OP_LDHI, 12'h000, 4'h0);          // new 000, old F01
    run(OP_JEQ,  12'h000, 4'h0);          // R3 not taken
    run(OP_LDHI, 12'h000, 4'h0);          // new 000, old 000
    run(OP_JEQ,  12'h000, 4'h0);          // R3 taken
    run(OP_ADDI, 12'h345, 4'h0);
    run(OP_MOVB, 12'h000, 4'h0);          // R6 B = A
    run(OP_LDP,  12'h003, 4'h0);
    run(OP_LDIX, 12'h000, 4'h5);          // R7
    run(OP_STB,  12'h000, 4'h0);          // R6 store backup
    run(OP_XLT,  12'h000, 4'h0);          // R8
    chk("R10", "rom addr", int'(rom_addr), int'(m_a));
    run(OP_ADDI, 12'h7FF, 4'h0);          // R8 skipped
    run(OP_STI,  12'h000, 4'h0);          // executes again
    run(OP_LDP,  12'h00E, 4'h0);
    run(OP_LDJ,  12'h123, 4'h0);
    run(OP_LJMP, 12'h000, 4'h0);          // R9 far jump
    run(OP_LDJ,  12'hFFF, 4'h0);
    run(OP_LDHI, 12'h000, 4'h0);
    run(OP_JNC,  12'h000, 4'h0);          // R9 local jump keeps page

    // constrained random
    void'($urandom(32'd24681));
    for (int n = 0; n < 3000; n++) begin
      op_e rop;
      logic [DW-1:0] rimm;
      rop  = op_e'($urandom_range(0, 15));
      rimm = DW'($urandom);
      if (($urandom_range(0, 3) == 0) && (rop == OP_ADDI)) rimm = 12'hFFF - m_a + 12'(($urandom_range(0, 2)));
      run(rop, rimm, OFW'($urandom));
      if (rop == OP_XLT) chk("R10", "rom addr", int'(rom_addr), int'(m_a));
    end
    finish_run();
  end
endmodule